// File: doc/BRIEF.md
# Configurable UART Frame Transmitter

This block turns one character at a time into an asynchronous serial frame on a single output line. A producer offers a 9-bit word with a valid/ready handshake. The word is taken only while the block is idle. A one-cycle bit-rate tick from an external divider sets the pace, and every bit on the line lasts from one tick to the next.

The frame format is chosen at runtime from a set of configuration inputs:
- character length of 7, 8 or 9 bits;
- parity of even, odd, forced zero or none;
- one or two stop bits;
- least- or most-significant bit first;
- normal or inverted line polarity.

The word and the format are captured together when a word is accepted, and they stay fixed until that frame has left the line. In 9-bit mode, bit 8 always follows the eight ordinary data bits, whichever order those are sent in. The parity bit, when enabled, comes after all character bits.

Top module: `uart_frame_tx`

## Requirements
- R1: After reset, with `cfg_line_invert` low, `tx_line` is 1, `busy` is 0 and `in_ready` is 1.
- R2: `in_ready` is high only while no frame is in progress. A word is accepted on a rising clock edge where `in_valid` and `in_ready` are both high. From the next cycle, `busy` is 1 and `in_ready` is 0, and further `in_valid` pulses are ignored until the frame ends.
- R3: After acceptance the line keeps its idle level until the first `bit_tick`. That tick starts the single start bit, which is logic 0. Each bit then holds its level until the next `bit_tick`.
- R4: `cfg_char_len` selects the number of character bits: 00 gives 7, 01 gives 8, and 10 or 11 give 9.
- R5: With `cfg_msb_first` = 0, data bits go out from bit 0 upward. With `cfg_msb_first` = 1, they go out from the top ordinary data bit downward: from bit 6 in 7-bit mode, and from bit 7 in 8-bit and 9-bit modes.
- R6: In 9-bit mode, bit 8 is sent right after the eight ordinary data bits in both orders.
- R7: `cfg_parity` selects the parity bit sent after the character bits: 00 sends no parity bit; 01 sends even parity, which makes the number of ones over the character bits and the parity bit even; 10 sends odd parity, which makes that count odd; 11 sends a parity bit that is always 0. Parity covers every enabled character bit, including bit 8.
- R8: After the parity bit (or the last character bit), one stop bit at logic 1 is sent when `cfg_two_stop` = 0, and two when it is 1.
- R9: With `cfg_line_invert` = 1, every frame bit is output inverted. The idle level in that case is 0, and it follows the input one cycle later while idle.
- R10: Changing the data input or any configuration input after acceptance has no effect on the frame in progress.
- R11: The tick that ends the last stop bit returns the line to idle. From the next cycle, `busy` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_tick | input | 1 | One-cycle pulse at the bit rate |
| in_valid | input | 1 | Word offered |
| in_data | input | 9 | Character, bit 8 used in 9-bit mode |
| in_ready | output | 1 | Block idle, word can be taken |
| cfg_char_len | input | 2 | Character length select |
| cfg_parity | input | 2 | Parity mode select |
| cfg_two_stop | input | 1 | Two stop bits when 1 |
| cfg_msb_first | input | 1 | Most-significant bit first when 1 |
| cfg_line_invert | input | 1 | Invert line level when 1 |
| tx_line | output | 1 | Serial output |
| busy | output | 1 | Frame in progress |

## Verification
The handshake results (`busy` high, `in_ready` low, line still at idle) are due in the cycle after the accepting edge. Each frame bit appears in the cycle after the edge that samples its tick, because the line is driven from a single register. The bench therefore raises the tick between edges, lets exactly one rising edge pass, and samples `tx_line` at the following falling edge. A second sample a few tick-free cycles later confirms that the level holds. The return to idle is checked in the cycle after the tick that ends the last stop bit. Expected bit sequences are built in the bench from the length, order, parity and stop settings.

// File: rtl/uart_tx_pkg.sv
// Shared types and frame-length helpers for the UART frame transmitter.
// Assumes a character of at most 9 bits and a frame of at most 13 bits.
package uart_tx_pkg;
    localparam int DATA_W   = 9;
    localparam int POS_W    = 4;
    localparam int CNT_W    = 4;

    typedef enum logic [1:0] {
        PAR_NONE = 2'b00,
        PAR_EVEN = 2'b01,
        PAR_ODD  = 2'b10,
        PAR_ZERO = 2'b11
    } par_mode_e;

    typedef struct packed {
        logic [1:0] len_sel;
        par_mode_e  par;
        logic       stop2;
        logic       msb_first;
        logic       invert;
    } tx_cfg_t;

    // Number of character bits for a length select code.
    function automatic logic [CNT_W-1:0] char_bits(input logic [1:0] sel);
        case (sel)
            2'b00:   char_bits = CNT_W'(7);
            2'b01:   char_bits = CNT_W'(8);
            default: char_bits = CNT_W'(9);
        endcase
    endfunction

    // Total bit slots in one frame: start + character + parity + stop.
    function automatic logic [POS_W-1:0] frame_bits(input tx_cfg_t c);
        logic [POS_W-1:0] n;
        n = POS_W'(1) + POS_W'(char_bits(c.len_sel));
        if (c.par != PAR_NONE) n = n + POS_W'(1);
        n = n + (c.stop2 ? POS_W'(2) : POS_W'(1));
        frame_bits = n;
    endfunction
endpackage

// File: rtl/uart_tx_parity.sv
// Computes the parity bit over the enabled character bits.
// Assumes data and cfg are the latched frame values (stable for a frame).
module uart_tx_parity
    import uart_tx_pkg::*;
(
    input  logic [DATA_W-1:0] data,
    input  tx_cfg_t           cfg,
    output logic              par_en,
    output logic              par_bit
);
    logic [CNT_W-1:0]  nchar;
    logic [DATA_W-1:0] masked;
    logic              ones_odd;

    assign nchar = char_bits(cfg.len_sel);

    // Keep only the bits that belong to the selected character length.
    for (genvar i = 0; i < DATA_W; i++) begin : g_mask
        assign masked[i] = data[i] & (CNT_W'(i) < nchar);
    end

    assign ones_odd = ^masked;

    // Select the parity bit for the configured mode.
    always_comb begin
        par_en  = (cfg.par != PAR_NONE);
        case (cfg.par)
            PAR_EVEN: par_bit = ones_odd;
            PAR_ODD:  par_bit = ~ones_odd;
            default:  par_bit = 1'b0;
        endcase
    end
endmodule

// File: rtl/uart_tx_bitmap.sv
// Maps a frame position to its line level before polarity inversion.
// Position 0 is the start bit; stop slots fill everything past parity.
module uart_tx_bitmap
    import uart_tx_pkg::*;
(
    input  logic [DATA_W-1:0] data,
    input  tx_cfg_t           cfg,
    input  logic [POS_W-1:0]  pos,
    input  logic              par_en,
    input  logic              par_bit,
    output logic              level
);
    logic [CNT_W-1:0] nchar;
    logic [CNT_W-1:0] dpos;
    logic [CNT_W-1:0] base;
    logic [CNT_W-1:0] idx;

    assign nchar = char_bits(cfg.len_sel);

    // Decode the slot: start, data (ordered), extension, parity or stop.
    always_comb begin
        level = 1'b1;
        dpos  = CNT_W'(pos) - CNT_W'(1);
        base  = (nchar == CNT_W'(7)) ? CNT_W'(7) : CNT_W'(8);
        idx   = cfg.msb_first ? (base - CNT_W'(1) - dpos) : dpos;
        if (pos == '0) begin
            level = 1'b0;
        end else if (CNT_W'(pos) <= nchar) begin
            if (dpos == CNT_W'(8)) level = data[DATA_W-1];
            else                   level = data[idx];
        end else if (par_en && (CNT_W'(pos) == nchar + CNT_W'(1))) begin
            level = par_bit;
        end
    end
endmodule

// File: rtl/uart_tx_ctrl.sv
// Handshake, frame sequencing and the registered line output.
// Assumes bit_tick is a single-cycle pulse; a frame starts on the first
// tick after acceptance so that the start bit lasts a full interval.
module uart_tx_ctrl
    import uart_tx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_tick,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  tx_cfg_t           cfg_in,
    input  logic              level,
    output logic              in_ready,
    output logic              busy,
    output logic [DATA_W-1:0] data_q,
    output tx_cfg_t           cfg_q,
    output logic [POS_W-1:0]  pos_nxt,
    output logic              tx_line
);
    typedef enum logic [1:0] {ST_IDLE, ST_ARM, ST_SEND} st_e;

    st_e              state;
    logic [POS_W-1:0] pos_q;
    logic             line_q;
    logic             last;

    assign in_ready = (state == ST_IDLE);
    assign busy     = (state != ST_IDLE);
    assign tx_line  = line_q;
    assign last     = (pos_q == frame_bits(cfg_q) - POS_W'(1));

    // Next slot index whose level the bit map presents.
    always_comb begin
        pos_nxt = (state == ST_SEND) ? pos_q + POS_W'(1) : '0;
    end

    // Frame state, latched word and format, and line register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            data_q <= '0;
            cfg_q  <= tx_cfg_t'('0);
            pos_q  <= '0;
            line_q <= 1'b1;
        end else begin
            case (state)
                ST_IDLE: begin
                    line_q <= ~cfg_in.invert;
                    if (in_valid) begin
                        data_q <= in_data;
                        cfg_q  <= cfg_in;
                        state  <= ST_ARM;
                    end
                end
                ST_ARM: begin
                    if (bit_tick) begin
                        state  <= ST_SEND;
                        pos_q  <= '0;
                        line_q <= level ^ cfg_q.invert;
                    end
                end
                default: begin
                    if (bit_tick) begin
                        if (last) begin
                            state  <= ST_IDLE;
                            line_q <= ~cfg_q.invert;
                        end else begin
                            pos_q  <= pos_nxt;
                            line_q <= level ^ cfg_q.invert;
                        end
                    end
                end
            endcase
        end
    end

    // R2
    accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> (busy && !in_ready));
    // R3
    line_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !bit_tick) |=> $stable(tx_line));
    // R3
    start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ARM && bit_tick) |=> (tx_line == cfg_q.invert));
    // R8
    stop_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SEND && last) |-> (tx_line == ~cfg_q.invert));
    // R11
    pos_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SEND) |-> (pos_q < frame_bits(cfg_q)));
endmodule

// File: rtl/uart_frame_tx.sv
// Top of the UART frame transmitter: packs the format inputs, ties the
// sequencer to the parity and bit-map logic. No baud generation inside.
module uart_frame_tx
    import uart_tx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bit_tick,
    input  logic       in_valid,
    input  logic [8:0] in_data,
    output logic       in_ready,
    input  logic [1:0] cfg_char_len,
    input  logic [1:0] cfg_parity,
    input  logic       cfg_two_stop,
    input  logic       cfg_msb_first,
    input  logic       cfg_line_invert,
    output logic       tx_line,
    output logic       busy
);
    tx_cfg_t           cfg_in;
    tx_cfg_t           cfg_q;
    logic [DATA_W-1:0] data_q;
    logic [POS_W-1:0]  pos_nxt;
    logic              par_en;
    logic              par_bit;
    logic              level;

    assign cfg_in = '{len_sel:   cfg_char_len,
                      par:       par_mode_e'(cfg_parity),
                      stop2:     cfg_two_stop,
                      msb_first: cfg_msb_first,
                      invert:    cfg_line_invert};

    uart_tx_ctrl i_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_tick (bit_tick),
        .in_valid (in_valid),
        .in_data  (in_data),
        .cfg_in   (cfg_in),
        .level    (level),
        .in_ready (in_ready),
        .busy     (busy),
        .data_q   (data_q),
        .cfg_q    (cfg_q),
        .pos_nxt  (pos_nxt),
        .tx_line  (tx_line)
    );

    uart_tx_parity i_par (
        .data    (data_q),
        .cfg     (cfg_q),
        .par_en  (par_en),
        .par_bit (par_bit)
    );

    uart_tx_bitmap i_map (
        .data    (data_q),
        .cfg     (cfg_q),
        .pos     (pos_nxt),
        .par_en  (par_en),
        .par_bit (par_bit),
        .level   (level)
    );

    // R9
    idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(!busy)) |-> (tx_line == !$past(cfg_line_invert)));
endmodule

// File: tb/test_uart_frame_tx.sv
`timescale 1ns/100ps
module test_uart_frame_tx;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_tick = 1'b0;
    logic       in_valid = 1'b0;
    logic [8:0] in_data = '0;
    logic       in_ready;
    logic [1:0] cfg_char_len = 2'b01;
    logic [1:0] cfg_parity = 2'b00;
    logic       cfg_two_stop = 1'b0;
    logic       cfg_msb_first = 1'b0;
    logic       cfg_line_invert = 1'b0;
    logic       tx_line;
    logic       busy;

    int checks = 0;
    int failures = 0;
    bit exp_bits[16];
    int exp_n;

    always #2.5 clk = ~clk;

    uart_frame_tx i_uart_frame_tx (
        .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .in_valid(in_valid),
        .in_data(in_data), .in_ready(in_ready), .cfg_char_len(cfg_char_len),
        .cfg_parity(cfg_parity), .cfg_two_stop(cfg_two_stop),
        .cfg_msb_first(cfg_msb_first), .cfg_line_invert(cfg_line_invert),
        .tx_line(tx_line), .busy(busy));

    task automatic chk(input bit ok, input string req, input int act, input int want);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, want);
        end
    endtask

    // Expected frame, built from the requirement text (R4..R8).
    function automatic void build(input logic [8:0] d, input int nb, input int par,
                                  input bit st2, input bit msb);
        int ones = 0;
        exp_n = 0;
        exp_bits[exp_n++] = 1'b0;
        if (msb) begin
            for (int i = (nb == 7 ? 6 : 7); i >= 0; i--) exp_bits[exp_n++] = d[i];
        end else begin
            for (int i = 0; i < (nb == 7 ? 7 : 8); i++) exp_bits[exp_n++] = d[i];
        end
        if (nb == 9) exp_bits[exp_n++] = d[8];
        for (int i = 0; i < nb; i++) ones += int'(d[i]);
        if (par == 1) exp_bits[exp_n++] = bit'(ones % 2);
        if (par == 2) exp_bits[exp_n++] = bit'((ones + 1) % 2);
        if (par == 3) exp_bits[exp_n++] = 1'b0;
        exp_bits[exp_n++] = 1'b1;
        if (st2) exp_bits[exp_n++] = 1'b1;
    endfunction

    task automatic pulse_tick();
        bit_tick = 1'b1;
        @(negedge clk);
        bit_tick = 1'b0;
    endtask

    // One full frame; disturb changes inputs and offers junk words mid-frame.
    task automatic run_frame(input logic [8:0] d, input logic [1:0] len, input logic [1:0] par,
                             input bit st2, input bit msb, input bit inv,
                             input bit disturb, input string req);
        int nb = (len == 2'b00) ? 7 : (len == 2'b01) ? 8 : 9;
        build(d, nb, int'(par), st2, msb);
        @(negedge clk);
        cfg_char_len = len; cfg_parity = par; cfg_two_stop = st2;
        cfg_msb_first = msb; cfg_line_invert = inv;
        in_data = d; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        chk(busy === 1'b1 && in_ready === 1'b0, "R2 busy after accept", int'(busy), 1);
        repeat (2) @(negedge clk);
        chk(tx_line === !inv, "R3 idle until first tick", int'(tx_line), int'(!inv));
        if (disturb) begin
            cfg_char_len = ~len; cfg_parity = ~par; cfg_two_stop = ~st2;
            cfg_msb_first = ~msb; in_data = ~d; in_valid = 1'b1;
        end
        for (int j = 0; j < exp_n; j++) begin
            pulse_tick();
            chk(tx_line === (exp_bits[j] ^ inv), {req, $sformatf(" bit %0d", j)},
                int'(tx_line), int'(exp_bits[j] ^ inv));
            if (j == 0) begin
                repeat (3) @(negedge clk);
                chk(tx_line === inv, "R3 start bit held", int'(tx_line), int'(inv));
            end
            if (disturb) chk(in_ready === 1'b0, "R2 not ready mid-frame", int'(in_ready), 0);
        end
        in_valid = 1'b0;
        cfg_char_len = len; cfg_parity = par; cfg_two_stop = st2; cfg_msb_first = msb;
        pulse_tick();
        chk(busy === 1'b0 && in_ready === 1'b1, "R11 idle after last stop", int'(busy), 0);
        chk(tx_line === !inv, "R11 idle line level", int'(tx_line), int'(!inv));
    endtask

    task automatic test_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(tx_line === 1'b1, "R1 line after reset", int'(tx_line), 1);
        chk(busy === 1'b0, "R1 busy after reset", int'(busy), 0);
        chk(in_ready === 1'b1, "R1 ready after reset", int'(in_ready), 1);
    endtask

    task automatic test_idle_invert();
        @(negedge clk);
        cfg_line_invert = 1'b1;
        @(negedge clk);
        chk(tx_line === 1'b0, "R9 inverted idle", int'(tx_line), 0);
        cfg_line_invert = 1'b0;
        @(negedge clk);
        chk(tx_line === 1'b1, "R9 normal idle", int'(tx_line), 1);
    endtask

    task automatic test_extra_tick_idle();
        pulse_tick();
        repeat (2) @(negedge clk);
        chk(busy === 1'b0 && tx_line === 1'b1, "R3 tick in idle starts nothing", int'(busy), 0);
    endtask

    initial begin
        test_reset();
        // R6 R7 9-bit even LSB-first, 0x155 -> parity 1
        run_frame(9'h155, 2'b10, 2'b01, 1'b0, 1'b0, 1'b0, 1'b0, "R6 R7 9b even lsb");
        // R5 R6 9-bit even MSB-first
        run_frame(9'h155, 2'b10, 2'b01, 1'b0, 1'b1, 1'b0, 1'b0, "R5 R6 9b even msb");
        // R4 R7 R8 7-bit odd LSB-first, two stops
        run_frame(9'h02B, 2'b00, 2'b10, 1'b1, 1'b0, 1'b0, 1'b0, "R4 R7 R8 7b odd");
        // R5 7-bit MSB-first starts at bit 6, no parity
        run_frame(9'h14D, 2'b00, 2'b00, 1'b0, 1'b1, 1'b0, 1'b0, "R5 7b msb none");
        // R7 forced-zero parity, 8-bit
        run_frame(9'h0A5, 2'b01, 2'b11, 1'b0, 1'b0, 1'b0, 1'b0, "R7 8b zero par");
        // R4 R7 9-bit odd with bit 8 set, code 11
        run_frame(9'h180, 2'b11, 2'b10, 1'b1, 1'b1, 1'b0, 1'b0, "R4 R7 9b odd");
        // R9 inverted frame
        run_frame(9'h0C3, 2'b01, 2'b01, 1'b1, 1'b1, 1'b1, 1'b0, "R9 inverted");
        // R10 R2 inputs changed and word offered mid-frame
        run_frame(9'h1E1, 2'b10, 2'b01, 1'b0, 1'b0, 1'b0, 1'b1, "R10 held cfg");
        test_idle_invert();
        test_extra_tick_idle();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule